// File: doc/BRIEF.md
# Configuration Image Loader and Validator

After reset this block fetches a 64-word, 16-bit configuration image from a word-addressed memory. It fetches the words one at a time over a request channel and a response channel, both valid/ready. While the words arrive it sums them and keeps the few words that carry configuration fields. When the last word has been taken, it judges the image. The image is accepted only if it carries the good signature code and its wraparound sum equals a fixed magic value. An accepted image is decoded into the device configuration outputs: a 48-bit station address, the four PCI identity values, two power figures and three link defaults. A rejected image leaves every output at its built-in default. In both cases the block raises a done flag and reports whether the checksum matched, so software can tell why an image was refused.

The request channel follows normal back-pressure rules. The loader raises `nvm_req_valid` with an address and holds both steady until `nvm_req_ready` is seen high at a clock edge. It then raises `nvm_rsp_ready` and waits for the word. A response transfers on the edge where `nvm_rsp_valid` and `nvm_rsp_ready` are both high. Only one read is ever in flight, so the memory may stall either channel for any number of cycles. A software write port can replace the station address at any time, and that value beats the one taken from the image.

Top module: `nvm_cfg_loader`

## Requirements
- R1: The loader requests words 0 to 63 in ascending order, exactly one request per word and only one read in flight. While `nvm_req_valid` is high and `nvm_req_ready` is low, the request and its address are held unchanged.
- R2: The image is accepted only when bits 15:14 of word 19 (13h) are 2'b10. The codes 2'b00, 2'b01 and 2'b11 reject it even if the checksum matches.
- R3: `csum_ok` is high after loading exactly when the 16-bit sum of all 64 words equals 16'hBABA. The sum starts at zero and drops every carry.
- R4: `cfg_valid` goes high only when both the signature and the checksum pass, and only then are outputs loaded from the image. Otherwise every output keeps its default: vendor 16'h8086, device 16'h1A2B, subsystem 16'h0000, subsystem vendor 16'h8086, station address 0, D0 power 8'h0D, D3 power 8'h01, force speed 0, force duplex 0, PHY power-down enable 1.
- R5: The station address is {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]}, taken from words 0 to 2 with the first address byte in bits 47:40.
- R6: When bit 0 of word 10 (0Ah) is 1, the vendor ID comes from word 14 (0Eh) and the device ID from word 13 (0Dh). When it is 0, both keep their defaults.
- R7: When bit 1 of word 10 is 1, the subsystem ID comes from word 11 (0Bh) and the subsystem vendor ID from word 12 (0Ch). When it is 0, both keep their defaults.
- R8: D0 power is bits 15:8 of word 16 (10h). D3 power is bits 4:0 of word 16, zero-extended to 8 bits, so bits 7:5 of that word have no effect.
- R9: In word 19, bit 4 sets force speed, bit 3 sets force duplex and bit 9 sets PHY power-down enable.
- R10: A pulse on `sw_addr_wr` sets the station address to `sw_addr_data` on the next cycle. This holds whether the write comes before, during or after loading, and a later image load does not overwrite it.
- R11: `load_done` rises one cycle after the last response is accepted and stays high until reset. After that no further requests are made and the configuration outputs do not change, except through R10.
- R12: In reset, and until loading finishes, `load_done`, `cfg_valid` and `csum_ok` are low and every configuration output shows its R4 default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nvm_req_valid | output | 1 | Read request valid |
| nvm_req_ready | input | 1 | Memory accepts request |
| nvm_req_addr | output | 6 | Word address of request |
| nvm_rsp_valid | input | 1 | Read data valid |
| nvm_rsp_ready | output | 1 | Loader accepts read data |
| nvm_rsp_data | input | 16 | Read data word |
| sw_addr_wr | input | 1 | Software station-address write strobe |
| sw_addr_data | input | 48 | Software station address |
| station_addr | output | 48 | Station address, first byte in bits 47:40 |
| vendor_id | output | 16 | PCI vendor ID |
| device_id | output | 16 | PCI device ID |
| subsys_id | output | 16 | PCI subsystem ID |
| subsys_vendor_id | output | 16 | PCI subsystem vendor ID |
| pwr_d0 | output | 8 | D0 power, 100 mW units |
| pwr_d3 | output | 8 | D3 power, 100 mW units |
| force_speed | output | 1 | Force-speed default |
| force_duplex | output | 1 | Full-duplex default |
| phy_pwrdn_en | output | 1 | PHY power-down enable default |
| cfg_valid | output | 1 | Image accepted and applied |
| csum_ok | output | 1 | Checksum matched |
| load_done | output | 1 | Loading finished |

## Verification
The hardest case to reach from the ports is a software address write that lands while the image is still streaming in. Loading must finish afterwards and must still not overwrite that address. The bench starts the write a few cycles after reset, well inside the 64-read window, and then lets the load complete. A second hard case is a memory that stalls both the request and the response channel in irregular patterns. The bench's memory model throttles its ready and valid signals from a cycle counter while it checks that every requested address arrives in order and exactly once.

// File: rtl/nvm_cfg_pkg.sv
package nvm_cfg_pkg;

  localparam int unsigned WORD_W = 16;

  // word positions decoded from the image
  localparam int unsigned W_SA0    = 0;
  localparam int unsigned W_SA1    = 1;
  localparam int unsigned W_SA2    = 2;
  localparam int unsigned W_INIT   = 10;
  localparam int unsigned W_SSID   = 11;
  localparam int unsigned W_SSVID  = 12;
  localparam int unsigned W_DID    = 13;
  localparam int unsigned W_VID    = 14;
  localparam int unsigned W_PWR    = 16;
  localparam int unsigned W_SHARED = 19;

  localparam int unsigned NSLOT = 10;

  localparam logic [1:0] SIG_GOOD = 2'b10;

  // slot number -> image word index
  function automatic int unsigned slot_word(input int unsigned s);
    case (s)
      0:       slot_word = W_SA0;
      1:       slot_word = W_SA1;
      2:       slot_word = W_SA2;
      3:       slot_word = W_INIT;
      4:       slot_word = W_SSID;
      5:       slot_word = W_SSVID;
      6:       slot_word = W_DID;
      7:       slot_word = W_VID;
      8:       slot_word = W_PWR;
      default: slot_word = W_SHARED;
    endcase
  endfunction

  typedef struct packed {
    logic [WORD_W-1:0] sa0;
    logic [WORD_W-1:0] sa1;
    logic [WORD_W-1:0] sa2;
    logic [WORD_W-1:0] init;
    logic [WORD_W-1:0] ssid;
    logic [WORD_W-1:0] ssvid;
    logic [WORD_W-1:0] did;
    logic [WORD_W-1:0] vid;
    logic [WORD_W-1:0] pwr;
    logic [WORD_W-1:0] shared;
  } shadow_t;

  typedef struct packed {
    logic [47:0] station;
    logic [15:0] vid;
    logic [15:0] did;
    logic [15:0] ssid;
    logic [15:0] ssvid;
    logic [7:0]  d0;
    logic [7:0]  d3;
    logic        fspd;
    logic        fdup;
    logic        phypd;
  } cfg_t;

  typedef enum logic [1:0] {SQ_REQ, SQ_WAIT, SQ_FIN, SQ_HALT} seq_state_t;

endpackage

// File: rtl/nvm_rd_seq.sv
module nvm_rd_seq
  import nvm_cfg_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  output logic          beat,
  output logic [AW-1:0] beat_idx,
  output logic          finish
);

  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  seq_state_t    state_q;
  logic [AW-1:0] idx_q;

  assign req_valid = (state_q == SQ_REQ);
  assign req_addr  = idx_q;
  assign rsp_ready = (state_q == SQ_WAIT);
  assign beat      = rsp_ready && rsp_valid;
  assign beat_idx  = idx_q;
  assign finish    = (state_q == SQ_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_REQ;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SQ_REQ:  if (req_ready) state_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (rsp_valid) begin
            if (idx_q == LAST) begin
              state_q <= SQ_FIN;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= SQ_REQ;
            end
          end
        end
        SQ_FIN:  state_q <= SQ_HALT;
        default: state_q <= SQ_HALT;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R1

  AST_FIN_ONCE: assert property (@(posedge clk) disable iff (rst)
    finish |=> !finish && !req_valid); // R11

endmodule

// File: rtl/nvm_csum_acc.sv
module nvm_csum_acc
  import nvm_cfg_pkg::*;
#(
  parameter logic [WORD_W-1:0] MAGIC = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic [WORD_W-1:0] data,
  output logic              match
);

  logic [WORD_W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (rst)       sum_q <= '0;
    else if (beat) sum_q <= sum_q + data;
  end

  assign match = (sum_q == MAGIC);

  AST_SUM_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !beat |=> $stable(sum_q)); // R3

endmodule

// File: rtl/nvm_shadow_cap.sv
module nvm_shadow_cap
  import nvm_cfg_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic [AW-1:0]     beat_idx,
  input  logic [WORD_W-1:0] data,
  output shadow_t           shadow
);

  logic [WORD_W-1:0] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int unsigned WIDX = slot_word(g);
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[g] <= '0;
      else if (beat && beat_idx == AW'(WIDX))
        slot_q[g] <= data;
    end
  end

  always_comb begin
    shadow.sa0    = slot_q[0];
    shadow.sa1    = slot_q[1];
    shadow.sa2    = slot_q[2];
    shadow.init   = slot_q[3];
    shadow.ssid   = slot_q[4];
    shadow.ssvid  = slot_q[5];
    shadow.did    = slot_q[6];
    shadow.vid    = slot_q[7];
    shadow.pwr    = slot_q[8];
    shadow.shared = slot_q[9];
  end

endmodule

// File: rtl/nvm_cfg_regs.sv
module nvm_cfg_regs
  import nvm_cfg_pkg::*;
#(
  parameter logic [47:0] DEF_STATION = 48'h0,
  parameter logic [15:0] DEF_VID     = 16'h8086,
  parameter logic [15:0] DEF_DID     = 16'h1A2B,
  parameter logic [15:0] DEF_SSID    = 16'h0000,
  parameter logic [15:0] DEF_SSVID   = 16'h8086,
  parameter logic [7:0]  DEF_D0      = 8'h0D,
  parameter logic [7:0]  DEF_D3      = 8'h01,
  parameter logic        DEF_PHYPD   = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        finish,
  input  logic        sum_ok,
  input  shadow_t     shadow,
  input  logic        sw_wr,
  input  logic [47:0] sw_addr,
  output cfg_t        cfg,
  output logic        valid,
  output logic        csum_good,
  output logic        done
);

  localparam cfg_t DEF_CFG = '{
    station: DEF_STATION, vid: DEF_VID, did: DEF_DID, ssid: DEF_SSID,
    ssvid: DEF_SSVID, d0: DEF_D0, d3: DEF_D3, fspd: 1'b0, fdup: 1'b0,
    phypd: DEF_PHYPD};

  logic sig_ok;
  logic accept;
  logic ovr_q;
  cfg_t img_cfg;

  assign sig_ok = (shadow.shared[15:14] == SIG_GOOD);
  assign accept = sig_ok && sum_ok;

  always_comb begin
    img_cfg.station = {shadow.sa0[7:0], shadow.sa0[15:8],
                       shadow.sa1[7:0], shadow.sa1[15:8],
                       shadow.sa2[7:0], shadow.sa2[15:8]};
    img_cfg.vid   = shadow.init[0] ? shadow.vid   : DEF_VID;
    img_cfg.did   = shadow.init[0] ? shadow.did   : DEF_DID;
    img_cfg.ssid  = shadow.init[1] ? shadow.ssid  : DEF_SSID;
    img_cfg.ssvid = shadow.init[1] ? shadow.ssvid : DEF_SSVID;
    img_cfg.d0    = shadow.pwr[15:8];
    img_cfg.d3    = {3'b000, shadow.pwr[4:0]};
    img_cfg.fspd  = shadow.shared[4];
    img_cfg.fdup  = shadow.shared[3];
    img_cfg.phypd = shadow.shared[9];
    if (ovr_q) img_cfg.station = cfg.station;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= DEF_CFG;
      valid     <= 1'b0;
      csum_good <= 1'b0;
      done      <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (finish) begin
        done      <= 1'b1;
        csum_good <= sum_ok;
        valid     <= accept;
        if (accept) cfg <= img_cfg;
      end
      if (sw_wr) begin
        cfg.station <= sw_addr;
        ovr_q       <= 1'b1;
      end
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R11

  AST_VALID_NEEDS_CSUM: assert property (@(posedge clk) disable iff (rst)
    valid |-> csum_good && done); // R4

  AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> cfg.station == $past(sw_addr)); // R10

  AST_DEFAULTS_KEPT: assert property (@(posedge clk) disable iff (rst)
    !valid |-> cfg.vid == DEF_VID && cfg.did == DEF_DID && cfg.d0 == DEF_D0
               && cfg.phypd == DEF_PHYPD && !cfg.fspd); // R4

  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(cfg.vid) && $stable(cfg.ssid) && $stable(cfg.d3)
             && $stable(valid)); // R11

endmodule

// File: rtl/nvm_cfg_loader.sv
module nvm_cfg_loader
  import nvm_cfg_pkg::*;
#(
  parameter int unsigned WORDS     = 64,
  parameter logic [15:0] MAGIC     = 16'hBABA,
  parameter logic [15:0] DEF_DID   = 16'h1A2B,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          nvm_req_valid,
  input  logic          nvm_req_ready,
  output logic [AW-1:0] nvm_req_addr,
  input  logic          nvm_rsp_valid,
  output logic          nvm_rsp_ready,
  input  logic [15:0]   nvm_rsp_data,
  input  logic          sw_addr_wr,
  input  logic [47:0]   sw_addr_data,
  output logic [47:0]   station_addr,
  output logic [15:0]   vendor_id,
  output logic [15:0]   device_id,
  output logic [15:0]   subsys_id,
  output logic [15:0]   subsys_vendor_id,
  output logic [7:0]    pwr_d0,
  output logic [7:0]    pwr_d3,
  output logic          force_speed,
  output logic          force_duplex,
  output logic          phy_pwrdn_en,
  output logic          cfg_valid,
  output logic          csum_ok,
  output logic          load_done
);

  logic          beat;
  logic [AW-1:0] beat_idx;
  logic          finish;
  logic          sum_match;
  shadow_t       shadow;
  cfg_t          cfg;

  nvm_rd_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(nvm_req_valid), .req_ready(nvm_req_ready),
    .req_addr(nvm_req_addr),
    .rsp_valid(nvm_rsp_valid), .rsp_ready(nvm_rsp_ready),
    .beat(beat), .beat_idx(beat_idx), .finish(finish));

  nvm_csum_acc #(.MAGIC(MAGIC)) u_csum (
    .clk(clk), .rst(rst), .beat(beat), .data(nvm_rsp_data),
    .match(sum_match));

  nvm_shadow_cap #(.WORDS(WORDS)) u_shadow (
    .clk(clk), .rst(rst), .beat(beat), .beat_idx(beat_idx),
    .data(nvm_rsp_data), .shadow(shadow));

  nvm_cfg_regs #(.DEF_DID(DEF_DID)) u_regs (
    .clk(clk), .rst(rst), .finish(finish), .sum_ok(sum_match),
    .shadow(shadow), .sw_wr(sw_addr_wr), .sw_addr(sw_addr_data),
    .cfg(cfg), .valid(cfg_valid), .csum_good(csum_ok), .done(load_done));

  assign station_addr     = cfg.station;
  assign vendor_id        = cfg.vid;
  assign device_id        = cfg.did;
  assign subsys_id        = cfg.ssid;
  assign subsys_vendor_id = cfg.ssvid;
  assign pwr_d0           = cfg.d0;
  assign pwr_d3           = cfg.d3;
  assign force_speed      = cfg.fspd;
  assign force_duplex     = cfg.fdup;
  assign phy_pwrdn_en     = cfg.phypd;

  AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !nvm_req_valid && !nvm_rsp_ready); // R11

endmodule

// File: tb/nvm_cfg_loader_test.sv
module nvm_cfg_loader_test;

  localparam logic [15:0] DEF_DID = 16'h1A2B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nvm_req_valid, nvm_req_ready;
  logic [5:0]  nvm_req_addr;
  logic        nvm_rsp_valid, nvm_rsp_ready;
  logic [15:0] nvm_rsp_data;
  logic        sw_addr_wr = 1'b0;
  logic [47:0] sw_addr_data = '0;
  logic [47:0] station_addr;
  logic [15:0] vendor_id, device_id, subsys_id, subsys_vendor_id;
  logic [7:0]  pwr_d0, pwr_d3;
  logic        force_speed, force_duplex, phy_pwrdn_en;
  logic        cfg_valid, csum_ok, load_done;

  int n_chk = 0;
  int n_fail = 0;
  logic stall = 1'b0;
  logic [15:0] img [64];

  // memory model state
  int   cyc = 0;
  int   req_cnt = 0;
  int   order_err = 0;
  logic [5:0] exp_addr = '0;
  logic [5:0] pend_addr = '0;
  logic pend = 1'b0;

  always #2 clk = ~clk;

  nvm_cfg_loader uut (
    .clk(clk), .rst(rst),
    .nvm_req_valid(nvm_req_valid), .nvm_req_ready(nvm_req_ready),
    .nvm_req_addr(nvm_req_addr),
    .nvm_rsp_valid(nvm_rsp_valid), .nvm_rsp_ready(nvm_rsp_ready),
    .nvm_rsp_data(nvm_rsp_data),
    .sw_addr_wr(sw_addr_wr), .sw_addr_data(sw_addr_data),
    .station_addr(station_addr), .vendor_id(vendor_id),
    .device_id(device_id), .subsys_id(subsys_id),
    .subsys_vendor_id(subsys_vendor_id), .pwr_d0(pwr_d0), .pwr_d3(pwr_d3),
    .force_speed(force_speed), .force_duplex(force_duplex),
    .phy_pwrdn_en(phy_pwrdn_en), .cfg_valid(cfg_valid), .csum_ok(csum_ok),
    .load_done(load_done));

  // memory responder with optional stalls on both channels
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      nvm_req_ready <= 1'b0;
      nvm_rsp_valid <= 1'b0;
      nvm_rsp_data  <= '0;
      pend      <= 1'b0;
      req_cnt   <= 0;
      order_err <= 0;
      exp_addr  <= '0;
    end else begin
      nvm_req_ready <= stall ? (cyc % 3 == 0) : 1'b1;
      if (nvm_req_valid && nvm_req_ready) begin
        if (nvm_req_addr != exp_addr) order_err <= order_err + 1;
        exp_addr  <= exp_addr + 1'b1;
        req_cnt   <= req_cnt + 1;
        pend_addr <= nvm_req_addr;
        pend      <= 1'b1;
      end
      if (pend && !nvm_rsp_valid && (!stall || cyc % 4 == 1)) begin
        nvm_rsp_valid <= 1'b1;
        nvm_rsp_data  <= img[pend_addr];
      end
      if (nvm_rsp_valid && nvm_rsp_ready) begin
        nvm_rsp_valid <= 1'b0;
        pend          <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fix_csum();
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) s = s + img[i];
    img[63] = 16'hBABA - s;
  endtask

  task automatic base_img();
    for (int i = 0; i < 64; i++) img[i] = 16'(i * 16'h0125 + 16'h0303);
    img[0]  = 16'hA000;
    img[1]  = 16'h12C9;
    img[2]  = 16'h5634;
    img[10] = 16'h0003;
    img[11] = 16'h5151;
    img[12] = 16'h7272;
    img[13] = 16'h3C3C;
    img[14] = 16'h4D4D;
    img[16] = 16'h2AF7;
    img[19] = 16'h8218;
    fix_csum();
  endtask

  task automatic start_load(input logic st);
    @(negedge clk);
    rst = 1'b1;
    stall = st;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!load_done && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " R11 done reached"}, 64'(load_done), 64'd1);
  endtask

  task automatic chk_defaults(input string tag, input logic [47:0] sa);
    chk({tag, " R4 station"}, 64'(station_addr), 64'(sa));
    chk({tag, " R4 vendor"}, 64'(vendor_id), 64'h8086);
    chk({tag, " R4 device"}, 64'(device_id), 64'(DEF_DID));
    chk({tag, " R4 subsys"}, 64'(subsys_id), 64'h0);
    chk({tag, " R4 ssvid"}, 64'(subsys_vendor_id), 64'h8086);
    chk({tag, " R4 power"}, {48'h0, pwr_d0, pwr_d3}, 64'h0D01);
    chk({tag, " R4 flags"}, {61'h0, force_speed, force_duplex, phy_pwrdn_en}, 64'b001);
  endtask

  task automatic t_reset();
    base_img();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 done in reset", 64'(load_done), 64'd0);
    chk("R12 valid in reset", {62'h0, cfg_valid, csum_ok}, 64'd0);
    chk_defaults("R12 reset", 48'h0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R12 done mid load", 64'(load_done), 64'd0);
    chk_defaults("R12 mid load", 48'h0);
  endtask

  task automatic t_full_load(input logic st);
    base_img();
    start_load(st);
    wait_done("full");
    chk("R1 request count", 64'(req_cnt), 64'd64);
    chk("R1 address order", 64'(order_err), 64'd0);
    chk("R3 csum_ok", 64'(csum_ok), 64'd1);
    chk("R4 cfg_valid", 64'(cfg_valid), 64'd1);
    chk("R5 station order", 64'(station_addr), 64'h00A0C9123456);
    chk("R6 vendor from image", 64'(vendor_id), 64'h4D4D);
    chk("R6 device from image", 64'(device_id), 64'h3C3C);
    chk("R7 subsys from image", 64'(subsys_id), 64'h5151);
    chk("R7 ssvid from image", 64'(subsys_vendor_id), 64'h7272);
    chk("R8 d0 power", 64'(pwr_d0), 64'h2A);
    chk("R8 d3 power masked", 64'(pwr_d3), 64'h17);
    chk("R9 shared flags", {61'h0, force_speed, force_duplex, phy_pwrdn_en}, 64'b111);
  endtask

  task automatic t_builtin_ids();
    base_img();
    img[10] = 16'h0000;
    img[19] = 16'h8000;
    img[16] = 16'h05E3;
    fix_csum();
    start_load(1'b0);
    wait_done("builtin");
    chk("R6 vendor builtin", 64'(vendor_id), 64'h8086);
    chk("R6 device builtin", 64'(device_id), 64'(DEF_DID));
    chk("R7 subsys builtin", 64'(subsys_id), 64'h0);
    chk("R7 ssvid builtin", 64'(subsys_vendor_id), 64'h8086);
    chk("R9 flags cleared", {61'h0, force_speed, force_duplex, phy_pwrdn_en}, 64'b000);
    chk("R8 d0/d3", {48'h0, pwr_d0, pwr_d3}, 64'h0503);
    // only the vendor/device bit set
    base_img();
    img[10] = 16'h0001;
    fix_csum();
    start_load(1'b0);
    wait_done("vid only");
    chk("R6 vendor loaded alone", 64'(vendor_id), 64'h4D4D);
    chk("R7 subsys kept alone", 64'(subsys_id), 64'h0);
  endtask

  task automatic t_bad_sig();
    for (int c = 0; c < 4; c++) begin
      if (c == 2) continue;
      base_img();
      img[19] = {2'(c), img[19][13:0]};
      fix_csum();
      start_load(1'b0);
      wait_done("badsig");
      chk("R2 csum still ok", 64'(csum_ok), 64'd1);
      chk("R2 image rejected", 64'(cfg_valid), 64'd0);
      chk_defaults("R2 badsig", 48'h0);
    end
  endtask

  task automatic t_bad_csum();
    base_img();
    img[63] = img[63] + 16'h0001;
    start_load(1'b1);
    wait_done("badcsum");
    chk("R3 csum_ok low", 64'(csum_ok), 64'd0);
    chk("R3 valid low", 64'(cfg_valid), 64'd0);
    chk_defaults("R3 badcsum", 48'h0);
  endtask

  task automatic t_sw_override();
    base_img();
    start_load(1'b1);
    repeat (10) @(negedge clk);
    sw_addr_data = 48'h0211_2233_4455;
    sw_addr_wr = 1'b1;
    @(negedge clk);
    sw_addr_wr = 1'b0;
    chk("R10 sw write mid load", 64'(station_addr), 64'h021122334455);
    wait_done("sw");
    chk("R10 image does not overwrite", 64'(station_addr), 64'h021122334455);
    chk("R10 rest applied", 64'(vendor_id), 64'h4D4D);
    sw_addr_data = 48'hCAFE_0000_BEEF;
    sw_addr_wr = 1'b1;
    @(negedge clk);
    sw_addr_wr = 1'b0;
    chk("R10 sw write after load", 64'(station_addr), 64'hCAFE0000BEEF);
  endtask

  task automatic t_done_stable();
    logic [15:0] v;
    base_img();
    start_load(1'b0);
    wait_done("stable");
    v = vendor_id;
    repeat (40) @(negedge clk);
    chk("R11 done held", 64'(load_done), 64'd1);
    chk("R11 no extra requests", 64'(req_cnt), 64'd64);
    chk("R11 vendor frozen", 64'(vendor_id), 64'(v));
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_full_load(1'b0);
    t_full_load(1'b1);
    t_builtin_ids();
    t_bad_sig();
    t_bad_csum();
    t_sw_override();
    t_done_stable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule